// File: doc/BRIEF.md
# Serial SAR Converter Read Controller

This block is the host side of a link to a 16-bit successive-approximation converter. The converter runs in a four-wire mode where its data output also reports when a conversion has finished. On a start request the controller raises the convert line while the select line is still high, which puts the converter in select mode. After a fixed lead it lowers the select line. It then watches the data line. That line idles high through a pull-up while the converter is busy. When it falls, the conversion is finished.

When that edge arrives the controller runs sixteen serial clock periods and takes in the word with the most significant bit first. It then raises the select line to end the readback, lowers the convert line one cycle later, and presents the word with a one-cycle strobe. The data input reaches the logic through a two-flop synchronizer. The serial clock high and low times come from a run-time divider. If the data line never falls, a run-time timeout ends the attempt and sets an error flag.

Top module: `sar_read_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, `adc_cnv` and `adc_sck` are low, `adc_sel` is high, and `sample_valid`, `timeout_err` and `sample_data` are zero. This also holds when reset is applied in the middle of a readback.
- R2: A high `start_req` seen in the idle state raises `adc_cnv` at the next clock edge. `adc_sel` is high when `adc_cnv` rises.
- R3: `adc_sel` falls exactly SEL_LEAD cycles after `adc_cnv` rises, and at no other time. It stays low until the readback or the timeout is over.
- R4: `adc_cnv` stays high from its rise until the cycle after `adc_sel` rises again, and falls in exactly that cycle.
- R5: End of conversion is a low level on `adc_sdo` after the synchronizer, seen while waiting. The first rising edge of `adc_sck` comes three cycles after the first cycle in which `adc_sdo` is low.
- R6: Each high phase and each low phase of `adc_sck` lasts max(`sck_half_div`, 2) clock cycles. A setting of 0 or 1 acts as 2. `adc_sck` is high only while `adc_cnv` is high and `adc_sel` is low, and it idles low.
- R7: Each readback makes exactly 16 falling edges on `adc_sck`, never a 17th. The readback ends by raising `adc_sel`.
- R8: The converter changes its data after each falling edge. The bit that follows falling edge k becomes bit 16-k of `sample_data`, so the word is taken MSB first. `sample_valid` is high for one cycle, in the cycle `adc_cnv` falls. `sample_data` keeps its value until the next strobe.
- R9: If `adc_sdo` is still high `conv_timeout`+1 cycles after `adc_sel` falls, `timeout_err` rises in that cycle together with `adc_sel`. `adc_cnv` falls in the next cycle and no strobe follows. The flag is cleared when the next start is accepted.
- R10: `start_req` is ignored while a conversion or readback is in progress. Each accepted start gives one rise of `adc_cnv` and at most one strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request one conversion and readback |
| sck_half_div | input | DIV_W | System clocks per serial clock phase, minimum 2 |
| conv_timeout | input | TO_W | Wait limit for end of conversion, in cycles |
| adc_sdo | input | 1 | Converter data line, pulled high when released |
| adc_cnv | output | 1 | Convert line to the converter |
| adc_sel | output | 1 | Select line to the converter |
| adc_sck | output | 1 | Serial clock to the converter |
| sample_data | output | DATA_W | Last word read, MSB first |
| sample_valid | output | 1 | One-cycle strobe for a new word |
| timeout_err | output | 1 | Set when a conversion attempt times out |

## Verification
The properties assume that `adc_sdo` moves only after a falling edge of `adc_sck`, or once the conversion ends with the select line low. They also assume that `start_req` and the divider are steady with respect to the clock. The bench meets these assumptions with a converter model: it counts down the conversion on the falling system clock and updates its data line shortly after each serial clock fall, away from the sampling edge. The model releases the line when the select line rises. Divider settings of 0 through 5 and conversion lengths both shorter and longer than typical cover the clamp and the timing paths. One model run never signals the end of conversion, to reach the timeout.

// File: rtl/sar_rd_pkg.sv
`timescale 1ns/1ps
package sar_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARM   = 3'd1,
    ST_WAIT  = 3'd2,
    ST_READ  = 3'd3,
    ST_LAST  = 3'd4,
    ST_DONE  = 3'd5,
    ST_ABORT = 3'd6
  } rd_state_t;

  localparam int MIN_PHASE_CYC = 2;

endpackage

// File: rtl/sar_sync.sv
`timescale 1ns/1ps
module sar_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RESET_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/sar_sck_phaser.sv
`timescale 1ns/1ps
module sar_sck_phaser
  import sar_rd_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             stop,
  input  logic [DIV_W-1:0] half_div,
  output logic             sck_o,
  output logic             low_end_o
);

  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(MIN_PHASE_CYC);

  logic [DIV_W-1:0] eff_div;
  logic [DIV_W-1:0] cnt;
  logic             started;
  logic             sck_r;
  logic             last_cyc;

  assign eff_div  = (half_div < MIN_DIV) ? MIN_DIV : half_div;
  assign last_cyc = (cnt == eff_div - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt     <= '0;
      started <= 1'b0;
      sck_r   <= 1'b0;
    end else if (!started) begin
      started <= 1'b1;
      sck_r   <= 1'b1;
      cnt     <= '0;
    end else if (last_cyc) begin
      cnt <= '0;
      if (!(!sck_r && stop)) sck_r <= ~sck_r;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign sck_o     = sck_r;
  assign low_end_o = en && started && !sck_r && last_cyc;

endmodule

// File: rtl/sar_shift_in.sv
`timescale 1ns/1ps
module sar_shift_in #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] word_o
);

  logic [W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst || clr) sreg <= '0;
    else if (shift) sreg <= {sreg[W-2:0], din};
  end

  assign word_o = sreg;

endmodule

// File: rtl/sar_read_ctrl.sv
`timescale 1ns/1ps
module sar_read_ctrl
  import sar_rd_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int DIV_W       = 8,
  parameter int TO_W        = 16,
  parameter int SEL_LEAD    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic [DIV_W-1:0]  sck_half_div,
  input  logic [TO_W-1:0]   conv_timeout,
  input  logic              adc_sdo,
  output logic              adc_cnv,
  output logic              adc_sel,
  output logic              adc_sck,
  output logic [DATA_W-1:0] sample_data,
  output logic              sample_valid,
  output logic              timeout_err
);

  localparam int BIT_W  = $clog2(DATA_W);
  localparam int LEAD_W = (SEL_LEAD > 1) ? $clog2(SEL_LEAD) : 1;
  localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(DATA_W - 1);
  localparam logic [LEAD_W-1:0] LEAD_END = LEAD_W'(SEL_LEAD - 1);

  rd_state_t         state;
  logic              cnv_r, sel_r, valid_r, err_r;
  logic [DATA_W-1:0] sample_r;
  logic [LEAD_W-1:0] lead_cnt;
  logic [TO_W-1:0]   wait_cnt;
  logic [BIT_W-1:0]  bit_cnt;
  logic              cap_pend;
  logic              sdo_s;
  logic              low_end;
  logic              sck_w;
  logic [DATA_W-1:0] word_w;

  sar_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (adc_sdo),
    .q   (sdo_s)
  );

  sar_sck_phaser #(.DIV_W(DIV_W)) u_phaser (
    .clk       (clk),
    .rst       (rst),
    .en        (state == ST_READ),
    .stop      (bit_cnt == LAST_BIT),
    .half_div  (sck_half_div),
    .sck_o     (sck_w),
    .low_end_o (low_end)
  );

  sar_shift_in #(.W(DATA_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .clr    (state == ST_ARM),
    .shift  (cap_pend),
    .din    (sdo_s),
    .word_o (word_w)
  );

  // the bit is taken one cycle after the low phase ends, past the synchronizer delay
  always_ff @(posedge clk) begin
    if (rst) cap_pend <= 1'b0;
    else     cap_pend <= low_end;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnv_r    <= 1'b0;
      sel_r    <= 1'b1;
      valid_r  <= 1'b0;
      err_r    <= 1'b0;
      sample_r <= '0;
      lead_cnt <= '0;
      wait_cnt <= '0;
      bit_cnt  <= '0;
    end else begin
      valid_r <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_req) begin
            cnv_r    <= 1'b1;
            err_r    <= 1'b0;
            lead_cnt <= '0;
            state    <= ST_ARM;
          end
        end
        ST_ARM: begin
          if (lead_cnt == LEAD_END) begin
            sel_r    <= 1'b0;
            wait_cnt <= '0;
            state    <= ST_WAIT;
          end else begin
            lead_cnt <= lead_cnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (!sdo_s) begin
            bit_cnt <= '0;
            state   <= ST_READ;
          end else if (wait_cnt == conv_timeout) begin
            err_r <= 1'b1;
            sel_r <= 1'b1;
            state <= ST_ABORT;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        ST_READ: begin
          if (low_end) begin
            if (bit_cnt == LAST_BIT) state <= ST_LAST;
            else                     bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_LAST: begin
          sel_r <= 1'b1;
          state <= ST_DONE;
        end
        ST_DONE: begin
          cnv_r    <= 1'b0;
          valid_r  <= 1'b1;
          sample_r <= word_w;
          state    <= ST_IDLE;
        end
        ST_ABORT: begin
          cnv_r <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign adc_cnv      = cnv_r;
  assign adc_sel      = sel_r;
  assign adc_sck      = sck_w;
  assign sample_data  = sample_r;
  assign sample_valid = valid_r;
  assign timeout_err  = err_r;

endmodule

// File: rtl/sar_read_ctrl_chk.sv
`timescale 1ns/1ps
module sar_read_ctrl_chk #(
  parameter int SEL_LEAD = 4
) (
  input logic clk,
  input logic rst,
  input logic adc_cnv,
  input logic adc_sel,
  input logic adc_sck,
  input logic sample_valid,
  input logic timeout_err
);

  logic [7:0] cnv_age;
  logic [7:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst || !adc_cnv)     cnv_age <= '0;
    else if (cnv_age != 8'hFF) cnv_age <= cnv_age + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !adc_sck)     hi_run <= '0;
    else if (hi_run != 8'hFF) hi_run <= hi_run + 1'b1;
  end

  p_sel_high_at_cnv_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_cnv) |-> adc_sel);

  p_sel_fall_window_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_sel) |-> (cnv_age == 8'(SEL_LEAD)));

  p_cnv_drop_after_sel_r4: assert property (@(posedge clk) disable iff (rst)
    (adc_cnv && $rose(adc_sel)) |=> !adc_cnv);

  p_sck_gated_r6: assert property (@(posedge clk) disable iff (rst)
    adc_sck |-> (adc_cnv && !adc_sel));

  p_sck_min_high_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_sck) |-> (hi_run >= 8'd2));

  p_valid_single_r8: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid);

  p_valid_with_cnv_fall_r8: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> $fell(adc_cnv));

  p_timeout_releases_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_err) |-> (adc_sel && !sample_valid));

endmodule

bind sar_read_ctrl sar_read_ctrl_chk #(.SEL_LEAD(SEL_LEAD)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .adc_cnv      (adc_cnv),
  .adc_sel      (adc_sel),
  .adc_sck      (adc_sck),
  .sample_valid (sample_valid),
  .timeout_err  (timeout_err)
);

// File: tb/sar_read_ctrl_tb.sv
`timescale 1ns/1ps
module sar_read_ctrl_tb;

  localparam int DATA_W   = 16;
  localparam int DIV_W    = 8;
  localparam int TO_W     = 16;
  localparam int SEL_LEAD = 4;
  localparam int NVEC     = 6;
  // {word[31:16], half divider[15:8], conversion cycles[7:0]}
  localparam logic [31:0] VEC [NVEC] = '{
    32'hA5C3_02_14, 32'h0000_03_0A, 32'hFFFF_02_28,
    32'h8001_05_0F, 32'h7FFE_01_19, 32'h1234_00_08
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_req = 1'b0;
  logic [DIV_W-1:0] sck_half_div = 8'd2;
  logic [TO_W-1:0]  conv_timeout = 16'd200;
  logic adc_sdo = 1'b1;
  logic adc_cnv, adc_sel, adc_sck, sample_valid, timeout_err;
  logic [DATA_W-1:0] sample_data;

  int checks = 0, fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sar_read_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .TO_W(TO_W), .SEL_LEAD(SEL_LEAD)) u_dut (
    .clk(clk), .rst(rst), .start_req(start_req), .sck_half_div(sck_half_div),
    .conv_timeout(conv_timeout), .adc_sdo(adc_sdo), .adc_cnv(adc_cnv), .adc_sel(adc_sel),
    .adc_sck(adc_sck), .sample_data(sample_data), .sample_valid(sample_valid),
    .timeout_err(timeout_err)
  );

  // converter model
  logic [15:0] m_word = '0;
  int  m_conv = 10;
  bit  m_stuck = 1'b0;
  bit  converting = 1'b0, reading = 1'b0;
  int  conv_left = 0, idx = 0, fall_cnt = 0;

  always @(posedge adc_cnv) if (adc_sel) begin converting = 1'b1; conv_left = m_conv; end
  always @(negedge adc_cnv) converting = 1'b0;
  always @(negedge clk) begin
    #2;
    if (converting) begin
      if (conv_left > 0) conv_left--;
      else if (!adc_sel && !m_stuck) begin
        adc_sdo = 1'b0; converting = 1'b0; reading = 1'b1; idx = 15;
      end
    end
  end
  always @(negedge adc_sck) begin
    fall_cnt++;
    #1;
    if (reading) begin
      if (idx >= 0) begin adc_sdo = m_word[idx]; idx--; end
      else begin adc_sdo = 1'b1; reading = 1'b0; end
    end
  end
  always @(posedge adc_sel) begin #1; adc_sdo = 1'b1; reading = 1'b0; end

  // monitors, sampled at the falling system clock
  logic p_sck = 0, p_sel = 1, p_cnv = 0, p_sdo = 1, p_err = 0;
  int hi_run, lo_run, hi_min, hi_max, lo_min, lo_max;
  int since_cnv, since_sel_rise, since_sel_fall, since_sdo;
  int lead_meas, drop_meas, eoc_lat, err_meas, valid_cnt, cnv_rises;
  bit sel_at_rise, eoc_armed, eoc_done;
  logic [15:0] got;

  task automatic mon_clear();
    hi_run = 0; lo_run = 0; hi_min = 999; hi_max = 0; lo_min = 999; lo_max = 0;
    lead_meas = -1; drop_meas = -1; eoc_lat = -1; err_meas = -1;
    valid_cnt = 0; cnv_rises = 0; sel_at_rise = 0; eoc_armed = 0; eoc_done = 0;
    fall_cnt = 0; got = '0;
  endtask

  always @(negedge clk) begin
    since_cnv++; since_sel_rise++; since_sel_fall++; since_sdo++;
    if (adc_cnv && !p_cnv) begin since_cnv = 0; cnv_rises++; sel_at_rise = adc_sel; end
    if (!adc_sel && p_sel) begin lead_meas = since_cnv; since_sel_fall = 0; end
    if (adc_sel && !p_sel) since_sel_rise = 0;
    if (!adc_cnv && p_cnv) drop_meas = since_sel_rise;
    if (!adc_sdo && p_sdo && adc_cnv && !adc_sel && !eoc_armed) begin eoc_armed = 1; since_sdo = 0; end
    if (adc_sck && !p_sck && eoc_armed && !eoc_done) begin eoc_done = 1; eoc_lat = since_sdo; end
    if (timeout_err && !p_err) err_meas = since_sel_fall;
    if (adc_sck) begin
      if (!p_sck && lo_run > 0) begin
        if (lo_run < lo_min) lo_min = lo_run;
        if (lo_run > lo_max) lo_max = lo_run;
      end
      hi_run++; lo_run = 0;
    end else if (p_sck) begin
      if (hi_run < hi_min) hi_min = hi_run;
      if (hi_run > hi_max) hi_max = hi_run;
      hi_run = 0; lo_run = 1;
    end else if (lo_run > 0) lo_run++;
    if (sample_valid) begin valid_cnt++; got = sample_data; end
    p_sck = adc_sck; p_sel = adc_sel; p_cnv = adc_cnv; p_sdo = adc_sdo; p_err = timeout_err;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_txn(input logic [15:0] w, input logic [7:0] div, input int conv,
                         input bit stuck, input int to, input int hold);
    @(negedge clk);
    m_word = w; m_conv = conv; m_stuck = stuck;
    sck_half_div = div; conv_timeout = 16'(to);
    mon_clear();
    start_req = 1'b1;
    @(negedge clk);
    repeat (hold) @(negedge clk);
    start_req = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if (!adc_cnv) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    mon_clear();
    since_cnv = 0; since_sel_rise = 0; since_sel_fall = 0; since_sdo = 0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!adc_cnv && adc_sel && !adc_sck, "R1", "lines in reset", {adc_cnv, adc_sel, adc_sck}, 3'b010);
    chk(!sample_valid && !timeout_err && sample_data == 0, "R1", "outputs in reset", int'(sample_data), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!adc_cnv && adc_sel && !adc_sck, "R1", "lines after reset", {adc_cnv, adc_sel, adc_sck}, 3'b010);

    // vector walk
    for (int v = 0; v < NVEC; v++) begin
      automatic logic [15:0] w  = VEC[v][31:16];
      automatic int          d  = int'(VEC[v][15:8]);
      automatic int          c  = int'(VEC[v][7:0]);
      automatic int          ed = (d < 2) ? 2 : d;
      run_txn(w, VEC[v][15:8], c, 1'b0, 200, 0);
      chk(got == w, "R8", "sample word", int'(got), int'(w));
      chk(valid_cnt == 1, "R8", "strobe count", valid_cnt, 1);
      chk(cnv_rises == 1 && sel_at_rise, "R2", "cnv rise with sel high", int'(sel_at_rise), 1);
      chk(lead_meas == SEL_LEAD, "R3", "sel fall lead", lead_meas, SEL_LEAD);
      chk(drop_meas == 1, "R4", "cnv fall after sel rise", drop_meas, 1);
      chk(eoc_lat == 3, "R5", "eoc to first sck rise", eoc_lat, 3);
      chk(hi_min == ed && hi_max == ed, "R6", "sck high phase", hi_max, ed);
      chk(lo_min == ed && lo_max == ed, "R6", "sck low phase", lo_min, ed);
      chk(fall_cnt == 16, "R7", "sck falling edges", fall_cnt, 16);
      chk(!timeout_err, "R9", "no timeout on normal run", int'(timeout_err), 0);
    end

    // R8 hold of the last word
    repeat (20) @(negedge clk);
    chk(sample_data == 16'h1234 && !sample_valid, "R8", "word held while idle", int'(sample_data), 16'h1234);

    // R9 timeout
    run_txn(16'h5555, 8'd2, 10, 1'b1, 30, 0);
    chk(timeout_err, "R9", "timeout flag", int'(timeout_err), 1);
    chk(err_meas == 31, "R9", "timeout delay from sel fall", err_meas, 31);
    chk(valid_cnt == 0, "R9", "no strobe on timeout", valid_cnt, 0);
    chk(fall_cnt == 0, "R9", "no sck on timeout", fall_cnt, 0);
    chk(drop_meas == 1 && !adc_cnv, "R9", "cnv dropped after timeout", drop_meas, 1);

    // R9 flag cleared by next start
    run_txn(16'h3C96, 8'd3, 12, 1'b0, 200, 0);
    chk(!timeout_err, "R9", "flag cleared by start", int'(timeout_err), 0);
    chk(got == 16'h3C96, "R8", "word after timeout", int'(got), 16'h3C96);

    // R10 start held during conversion
    run_txn(16'hC0DE, 8'd2, 20, 1'b0, 200, 30);
    chk(cnv_rises == 1, "R10", "single cnv rise while start held", cnv_rises, 1);
    chk(valid_cnt == 1, "R10", "single strobe while start held", valid_cnt, 1);
    chk(got == 16'hC0DE, "R10", "word with start held", int'(got), 16'hC0DE);

    // R1 reset during readback
    @(negedge clk);
    m_word = 16'hFFFF; m_conv = 6; m_stuck = 1'b0; sck_half_div = 8'd4;
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (fall_cnt >= 4) break;
      @(negedge clk);
    end
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!adc_cnv && adc_sel && !adc_sck, "R1", "lines after mid-read reset", {adc_cnv, adc_sel, adc_sck}, 3'b010);
    chk(sample_data == 0 && !sample_valid, "R1", "word after mid-read reset", int'(sample_data), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule